// File: doc/BRIEF.md
# Post-Execution Breakpoint PC Capture

This block sits beside an in-order core that retires at most one 16-bit instruction per cycle. For every retirement it receives the instruction address, the sequential successor address, a flag for a delayed branch, that branch's target, and a marker for a delay-slot instruction. It compares each retiring address against a programmed break address. A per-bit mask chooses which address bits take part in the compare. It also accepts a one-cycle pulse from an external bus comparator that reports a CPU or DMA data-access match.

When a break condition holds, the block raises a registered user-break request at the right instruction boundary. It also presents the program counter value that the exception entry logic should save. An instruction-fetch break is taken after the matching instruction completes. On a delayed branch, the break waits until the delay slot has run, and the saved PC is the branch destination. A data-access break is imprecise on purpose: it is held pending and taken a programmable number of retirements later. The request and the saved PC hold steady until the exception logic acknowledges them.

Top module: `brk_capture`

## Requirements
- R1: After reset, `brk_req` is 0 and `brk_pc` is 0.
- R2: When an enabled fetch compare matches a retiring instruction that is not a delayed branch, `brk_req` is 1 in the next cycle. `brk_pc` is then that instruction's successor: `ret_next`, or the last delayed-branch target if the instruction was a delay slot (`ret_slot`=1).
- R3: Address bit i takes part in the compare only when `brk_mask[i]` is 1. A difference in a bit whose mask bit is 0 still matches. A difference in a bit whose mask bit is 1 gives no break.
- R4: A fetch match on a delayed branch (`ret_dbranch`=1) raises no request in the next cycle. The request follows the retirement of the delay slot, with `brk_pc` equal to the branch target.
- R5: A `data_hit` pulse is taken on the (DATA_LAT+1)-th retirement strictly after the pulse cycle, where DATA_LAT is 0 to 2. `brk_pc` is then that retirement's successor. A retirement in the same cycle as the pulse is not counted.
- R6: If a pending data break comes due on a delayed branch, it moves to that branch's delay slot, and `brk_pc` is the branch target.
- R7: While a request is up or a break is pending, new fetch matches and data pulses are discarded and leave no trace. When a fetch match and a data pulse arrive in the same idle cycle, the fetch break is taken and the data pulse is discarded.
- R8: `brk_req` and `brk_pc` stay unchanged until `ack` is asserted. `brk_req` is 0 in the cycle after `ack`, and `ack` also clears any pending break.
- R9: With `brk_en`=0 the fetch compare never matches; data pulses still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_addr | input | AW | Address of the retiring instruction |
| ret_next | input | AW | Sequential successor address |
| ret_dbranch | input | 1 | Retiring instruction is a delayed branch |
| ret_target | input | AW | Destination of that delayed branch |
| ret_slot | input | 1 | Retiring instruction is a delay slot |
| brk_en | input | 1 | Enables the fetch-address compare |
| brk_addr | input | AW | Programmed break address |
| brk_mask | input | AW | Compare mask, 1 = bit compared |
| data_hit | input | 1 | Data-access match pulse from the bus comparator |
| ack | input | 1 | Exception logic accepts the break |
| brk_req | output | 1 | User-break request |
| brk_pc | output | AW | PC value to save |

## Verification
A fetch-address match and a data-access pulse can land in the same idle cycle, and both try to claim the single break slot. The bench drives a matching retirement with `data_hit` high in that same cycle. It expects exactly one request, whose PC is the fetch successor. It then retires further instructions past the data latency and requires that no second request appears. The same idea covers pulses and matches that arrive while a request is up: the saved PC must stay put, and nothing may fire after the acknowledge.

// File: rtl/brk_capture.sv
module brk_capture #(
  parameter int AW       = 32,
  parameter int DATA_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic [AW-1:0] ret_next,
  input  logic          ret_dbranch,
  input  logic [AW-1:0] ret_target,
  input  logic          ret_slot,
  input  logic          brk_en,
  input  logic [AW-1:0] brk_addr,
  input  logic [AW-1:0] brk_mask,
  input  logic          data_hit,
  input  logic          ack,
  output logic          brk_req,
  output logic [AW-1:0] brk_pc
);
  localparam int CW = $clog2(DATA_LAT + 2);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [AW-1:0] tgt_q;

  wire           addr_hit = ((ret_addr ^ brk_addr) & brk_mask) == '0;
  wire           busy     = brk_req | armed;
  wire           f_hit    = ret_valid & brk_en & addr_hit & ~busy & ~ack;
  wire           d_hit    = data_hit & ~busy & ~ack & ~f_hit;
  wire [AW-1:0]  succ     = ret_slot ? tgt_q : ret_next;
  wire           due      = armed & ret_valid & (cnt == '0);
  wire           take     = due & ~ret_dbranch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_req <= 1'b0;
      brk_pc  <= '0;
      armed   <= 1'b0;
      cnt     <= '0;
      tgt_q   <= '0;
    end else begin
      if (ret_valid && ret_dbranch) tgt_q <= ret_target;
      if (ack) begin
        brk_req <= 1'b0;
        armed   <= 1'b0;
        cnt     <= '0;
      end else if (f_hit && !ret_dbranch) begin
        brk_req <= 1'b1;
        brk_pc  <= succ;
      end else if (f_hit) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (d_hit) begin
        armed <= 1'b1;
        cnt   <= CW'(DATA_LAT);
      end else if (take) begin
        armed   <= 1'b0;
        brk_req <= 1'b1;
        brk_pc  <= succ;
      end else if (armed && ret_valid && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/brk_capture_chk.sv
module brk_capture_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ret_valid,
  input logic [AW-1:0] ret_addr,
  input logic          ret_dbranch,
  input logic          brk_en,
  input logic [AW-1:0] brk_addr,
  input logic [AW-1:0] brk_mask,
  input logic          ack,
  input logic          brk_req,
  input logic [AW-1:0] brk_pc,
  input logic          armed
);
  logic m;
  assign m = ret_valid && brk_en && (((ret_addr ^ brk_addr) & brk_mask) == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !ack |=> brk_req && $stable(brk_pc));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !brk_req);

  assert_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m && !ret_dbranch && !brk_req && !armed && !ack |=> brk_req);

  assert_defer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m && ret_dbranch && !brk_req && !armed && !ack |=> !brk_req && armed);

  assert_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(ret_valid));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !ack |=> !armed);
endmodule

bind brk_capture brk_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
  .ret_dbranch(ret_dbranch), .brk_en(brk_en), .brk_addr(brk_addr),
  .brk_mask(brk_mask), .ack(ack), .brk_req(brk_req), .brk_pc(brk_pc),
  .armed(armed)
);

// File: tb/brk_capture_test.sv
`timescale 1ns/1ps
module brk_capture_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ret_valid = 0, ret_dbranch = 0, ret_slot = 0;
  logic [31:0] ret_addr = 0, ret_next = 0, ret_target = 0;
  logic        brk_en = 0;
  logic [31:0] brk_addr = 0, brk_mask = 0;
  logic        data_hit = 0, ack = 0;
  logic        brk_req;
  logic [31:0] brk_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_req = 0;
  logic [31:0] held = 0;

  brk_capture #(.AW(32), .DATA_LAT(1)) uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .ret_next(ret_next), .ret_dbranch(ret_dbranch), .ret_target(ret_target),
    .ret_slot(ret_slot), .brk_en(brk_en), .brk_addr(brk_addr),
    .brk_mask(brk_mask), .data_hit(data_hit), .ack(ack),
    .brk_req(brk_req), .brk_pc(brk_pc));

  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_pc(string tag, logic [31:0] pc);
    exp_q.push_back(pc);
    tag_q.push_back(tag);
  endtask

  task automatic retire(logic [31:0] a, logic [31:0] nx, logic dbr,
                        logic [31:0] tg, logic sl, logic dh);
    @(negedge clk);
    ret_addr = a; ret_next = nx; ret_dbranch = dbr; ret_target = tg;
    ret_slot = sl; data_hit = dh; ret_valid = 1;
    @(negedge clk);
    ret_valid = 0; ret_dbranch = 0; ret_slot = 0; data_hit = 0;
  endtask

  task automatic pulse_data();
    @(negedge clk); data_hit = 1;
    @(negedge clk); data_hit = 0;
  endtask

  task automatic do_ack(string tag);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    check(tag, {31'b0, brk_req}, 32'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (brk_req && !prev_req) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R7 unexpected request actual=%h expected=none", brk_pc);
        end else begin
          string t;
          logic [31:0] e;
          t = tag_q.pop_front();
          e = exp_q.pop_front();
          check(t, brk_pc, e);
        end
        held = brk_pc;
      end else if (brk_req && brk_pc !== held) begin
        n_chk++; n_bad++;
        $display("FAIL R8 pc moved actual=%h expected=%h", brk_pc, held);
      end
      prev_req = brk_req;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 req", {31'b0, brk_req}, 32'd0);
    check("R1 pc", brk_pc, 32'd0);

    brk_en = 1; brk_addr = 32'h100; brk_mask = 32'hFFFF_FFFF;
    retire(32'h0FC, 32'h0FE, 0, 0, 0, 0);
    check("R2 no match", {31'b0, brk_req}, 32'd0);
    expect_pc("R2 fetch", 32'h102);
    retire(32'h100, 32'h102, 0, 0, 0, 0);
    check("R2 req", {31'b0, brk_req}, 32'd1);
    repeat (3) @(negedge clk);
    check("R8 held", {31'b0, brk_req}, 32'd1);
    do_ack("R8 drop");

    brk_addr = 32'h200; brk_mask = 32'hFFFF_FFF0;
    expect_pc("R3 masked", 32'h20C);
    retire(32'h20A, 32'h20C, 0, 0, 0, 0);
    do_ack("R3 ack");
    retire(32'h21A, 32'h21C, 0, 0, 0, 0);
    check("R3 compared bit", {31'b0, brk_req}, 32'd0);
    brk_en = 0;
    retire(32'h200, 32'h202, 0, 0, 0, 0);
    check("R9 disabled", {31'b0, brk_req}, 32'd0);
    brk_en = 1;

    brk_addr = 32'h300; brk_mask = 32'hFFFF_FFFF;
    retire(32'h300, 32'h302, 1, 32'h500, 0, 0);
    check("R4 deferred", {31'b0, brk_req}, 32'd0);
    expect_pc("R4 target", 32'h500);
    retire(32'h302, 32'h304, 0, 0, 1, 0);
    check("R4 req", {31'b0, brk_req}, 32'd1);
    do_ack("R4 ack");

    brk_addr = 32'hF000;
    pulse_data();
    retire(32'h400, 32'h402, 0, 0, 0, 0);
    check("R5 latency", {31'b0, brk_req}, 32'd0);
    expect_pc("R5 data", 32'h404);
    retire(32'h402, 32'h404, 0, 0, 0, 0);
    do_ack("R5 ack");

    brk_en = 0;
    expect_pc("R9 data still", 32'h484);
    retire(32'h480, 32'h482, 0, 0, 0, 1);
    retire(32'h482, 32'h484, 0, 0, 0, 0);
    check("R5 pulse cycle not counted", {31'b0, brk_req}, 32'd0);
    retire(32'h484 - 32'h2, 32'h484, 0, 0, 0, 0);
    do_ack("R9 ack");
    brk_en = 1;

    pulse_data();
    retire(32'h600, 32'h602, 0, 0, 0, 0);
    retire(32'h602, 32'h604, 1, 32'h700, 0, 0);
    check("R6 deferred", {31'b0, brk_req}, 32'd0);
    expect_pc("R6 target", 32'h700);
    retire(32'h604, 32'h606, 0, 0, 1, 0);
    do_ack("R6 ack");

    brk_addr = 32'h800;
    expect_pc("R7 first", 32'h802);
    retire(32'h800, 32'h802, 0, 0, 0, 0);
    retire(32'h800, 32'h9F0, 0, 0, 0, 1);
    pulse_data();
    check("R7 pc kept", brk_pc, 32'h802);
    do_ack("R7 ack");
    retire(32'h900, 32'h902, 0, 0, 0, 0);
    retire(32'h902, 32'h904, 0, 0, 0, 0);
    retire(32'h904, 32'h906, 0, 0, 0, 0);
    check("R7 no residue", {31'b0, brk_req}, 32'd0);

    expect_pc("R7 same cycle", 32'h802);
    retire(32'h800, 32'h802, 0, 0, 0, 1);
    do_ack("R7 same ack");
    retire(32'hA00, 32'hA02, 0, 0, 0, 0);
    retire(32'hA02, 32'hA04, 0, 0, 0, 0);
    retire(32'hA04, 32'hA06, 0, 0, 0, 0);
    check("R7 data dropped", {31'b0, brk_req}, 32'd0);

    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing requests actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule